// File: doc/BRIEF.md
# Interrupt Long-Branch Vector Responder

This block answers the processor's instruction fetch after an interrupt is taken. Three consecutive vector reads return a complete long-branch instruction: the opcode byte 0xC0, then a programmable page byte, then a low address byte. The low byte is built from a programmable base and the number of the winning request. The request number is shifted by a selectable spacing, so that each service routine gets 2, 4, 8 or 16 bytes. A polling read returns the same low byte without starting a sequence, so software can find the requesting source by polling.

The block holds the page and control registers. It takes the winning request index and a valid flag from a separate priority core, plus a defer flag from a higher-priority cascaded unit. It returns a one-hot clear pulse for the latch being serviced, and one-cycle pulses that tell the priority core to clear all latches or all masks. Chip-select and address decoding sit outside the block. Every output is registered and appears one clock after the strobe that causes it.

Top module: `lbr_vector_seq`

## Requirements
- R1: After reset, `rd_oe`, `rd_data`, `clr_req`, `latch_clr_all` and `mask_clr_all` are all zero, the page and control registers hold zero, and the sequence waits for its opcode byte.
- R2: Three consecutive accepted `vec_rd` strobes return, one cycle after each strobe and with `rd_oe` high, the bytes 0xC0, then the page byte, then the low vector byte.
- R3: The page byte is the last value written with `wr_page`, returned unmodified, whatever the request index is.
- R4: The low vector byte uses control bits [1:0] as the spacing code. Codes 00, 01, 10 and 11 place the 3-bit request number at bit 1, 2, 3 or 4. Bits below the number read 0. Bits above the number come from control bits [7:4] at bits [7:4], and any bit of [7:4] that the number covers takes the number's bit instead.
- R5: In the cycle the opcode byte is presented, `clr_req` carries exactly one bit, at the winning index. In every other cycle `clr_req` is zero.
- R6: The low byte of a sequence uses the index captured when its opcode byte was accepted, even if `win_idx` changes afterwards.
- R7: A `vec_rd` in the opcode phase while `defer` is high or `win_vld` is low produces no output enable and no clear, and the next accepted read still returns the opcode.
- R8: After the third byte the sequence restarts, so the next accepted `vec_rd` returns 0xC0 again.
- R9: A `poll_rd` returns, one cycle later with `rd_oe` high, the low byte formed from the current `win_idx`. It neither advances the sequence nor raises `clr_req`.
- R10: A `wr_ctrl` whose data bit 3 is 0 raises `latch_clr_all` for one cycle, and one whose bit 2 is 0 raises `mask_clr_all` for one cycle. A 1 in either bit raises no pulse.
- R11: When `vec_rd` and `poll_rd` arrive in the same cycle, the vector read is served and the poll is ignored.
- R12: `rd_oe` is high only in the cycle after a read strobe, and `rd_data` is zero whenever `rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_page | input | 1 | Write strobe for the page register |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data shared by both registers |
| vec_rd | input | 1 | Vector read strobe, one per byte |
| poll_rd | input | 1 | Polling read strobe |
| win_idx | input | 3 | Index of the highest-priority unmasked pending request |
| win_vld | input | 1 | An unmasked request is pending |
| defer | input | 1 | A higher-priority cascaded unit is requesting |
| rd_data | output | 8 | Read data byte |
| rd_oe | output | 1 | Read data is valid and driven |
| clr_req | output | 8 | One-hot clear pulse for the serviced latch |
| latch_clr_all | output | 1 | Pulse: clear all request latches |
| mask_clr_all | output | 1 | Pulse: clear all mask bits |

## Verification
The bench aims at the index freeze. It changes `win_idx` between the opcode byte and the low byte, so a design that read the live index would branch to a different routine than the one whose latch it cleared. It sweeps all four spacing codes with the largest index, which catches a wrong shift or a base bit leaking into the request field. It also issues deferred and invalid reads and simultaneous vector and poll reads. A design that counted on a deferred read would return the page byte first, and one that let the poll win would corrupt the branch sequence. Long random runs with a cycle-level reference model mix page and control writes with reads to catch ordering errors between register updates and output bytes.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int unsigned LBR_DATA_W  = 8;
  localparam int unsigned LBR_NUM_REQ = 8;
  localparam int unsigned LBR_IVL_W   = 2;
  localparam int unsigned LBR_BASE_W  = 4;

  // position in the three-byte branch response
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_PAGE = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;
endpackage

// File: rtl/lbr_regs.sv
module lbr_regs #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BASE_W    = 4,
  parameter int unsigned IVL_W     = 2,
  parameter int unsigned LATCH_BIT = 3,
  parameter int unsigned MASK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_page,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] page_q,
  output logic [BASE_W-1:0] base_q,
  output logic [IVL_W-1:0]  ivl_q,
  output logic              latch_clr_q,
  output logic              mask_clr_q
);
  localparam int unsigned BASE_LSB = DATA_W - BASE_W;

  logic latch_clr_d;
  logic mask_clr_d;

  always_comb begin
    latch_clr_d = wr_ctrl && !wr_data[LATCH_BIT];
    mask_clr_d  = wr_ctrl && !wr_data[MASK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_page) begin
      page_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ivl_q  <= '0;
    end else if (wr_ctrl) begin
      base_q <= wr_data[DATA_W-1:BASE_LSB];
      ivl_q  <= wr_data[IVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_clr_q <= 1'b0;
      mask_clr_q  <= 1'b0;
    end else begin
      latch_clr_q <= latch_clr_d;
      mask_clr_q  <= mask_clr_d;
    end
  end
endmodule

// File: rtl/lbr_lowbyte.sv
module lbr_lowbyte #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BASE_W = 4,
  parameter int unsigned IVL_W  = 2,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [BASE_W-1:0] base,
  input  logic [IVL_W-1:0]  ivl,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] low
);
  localparam int unsigned BASE_LSB = DATA_W - BASE_W;

  logic [IVL_W:0]    shamt;
  logic [DATA_W-1:0] base_full;
  logic [DATA_W-1:0] field;
  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] below_mask;

  always_comb begin
    shamt      = {1'b0, ivl} + (IVL_W + 1)'(1);
    base_full  = {base, {BASE_LSB{1'b0}}};
    field      = {{(DATA_W-IDX_W){1'b0}}, idx} << shamt;
    field_mask = {{(DATA_W-IDX_W){1'b0}}, {IDX_W{1'b1}}} << shamt;
    below_mask = (DATA_W'(1) << shamt) - DATA_W'(1);
    low        = field | (base_full & ~field_mask & ~below_mask);
  end
endmodule

// File: rtl/lbr_seq.sv
module lbr_seq
  import lbr_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_rd,
  input  logic             win_vld,
  input  logic             defer,
  input  logic [IDX_W-1:0] win_idx,
  output phase_t           phase_q,
  output logic [IDX_W-1:0] held_idx_q,
  output logic             fire_opc,
  output logic             fire_page,
  output logic             fire_low
);
  phase_t phase_d;
  logic   phase_en;

  always_comb begin
    fire_opc  = vec_rd && (phase_q == PH_OPC) && win_vld && !defer;
    fire_page = vec_rd && (phase_q == PH_PAGE);
    fire_low  = vec_rd && (phase_q == PH_LOW);
    phase_en  = fire_opc || fire_page || fire_low;
    phase_d   = phase_q;
    if (fire_opc)       phase_d = PH_PAGE;
    else if (fire_page) phase_d = PH_LOW;
    else if (fire_low)  phase_d = PH_OPC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_idx_q <= '0;
    end else if (fire_opc) begin
      held_idx_q <= win_idx;
    end
  end
endmodule

// File: rtl/lbr_vector_seq.sv
module lbr_vector_seq
  import lbr_pkg::*;
#(
  parameter int unsigned DATA_W  = LBR_DATA_W,
  parameter int unsigned NUM_REQ = LBR_NUM_REQ,
  parameter logic [7:0]  OPCODE  = 8'hC0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_page,
  input  logic                       wr_ctrl,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       vec_rd,
  input  logic                       poll_rd,
  input  logic [$clog2(NUM_REQ)-1:0] win_idx,
  input  logic                       win_vld,
  input  logic                       defer,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_oe,
  output logic [NUM_REQ-1:0]         clr_req,
  output logic                       latch_clr_all,
  output logic                       mask_clr_all
);
  localparam int unsigned IDX_W  = $clog2(NUM_REQ);
  localparam int unsigned BASE_W = LBR_BASE_W;
  localparam int unsigned IVL_W  = LBR_IVL_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [DATA_W-1:0] page_q;
  logic [BASE_W-1:0] base_q;
  logic [IVL_W-1:0]  ivl_q;

  lbr_regs #(
    .DATA_W(DATA_W), .BASE_W(BASE_W), .IVL_W(IVL_W),
    .LATCH_BIT(3), .MASK_BIT(2)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_page(wr_page), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .page_q(page_q), .base_q(base_q), .ivl_q(ivl_q),
    .latch_clr_q(latch_clr_all), .mask_clr_q(mask_clr_all)
  );

  phase_t           seq_phase;
  logic [IDX_W-1:0] held_idx;
  logic             fire_opc;
  logic             fire_page;
  logic             fire_low;

  lbr_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .vec_rd(vec_rd), .win_vld(win_vld), .defer(defer), .win_idx(win_idx),
    .phase_q(seq_phase), .held_idx_q(held_idx),
    .fire_opc(fire_opc), .fire_page(fire_page), .fire_low(fire_low)
  );

  logic [DATA_W-1:0] low_held;
  logic [DATA_W-1:0] low_live;

  lbr_lowbyte #(.DATA_W(DATA_W), .BASE_W(BASE_W), .IVL_W(IVL_W), .IDX_W(IDX_W))
    u_low_vec (.base(base_q), .ivl(ivl_q), .idx(held_idx), .low(low_held));

  lbr_lowbyte #(.DATA_W(DATA_W), .BASE_W(BASE_W), .IVL_W(IVL_W), .IDX_W(IDX_W))
    u_low_poll (.base(base_q), .ivl(ivl_q), .idx(win_idx), .low(low_live));

  logic [DATA_W-1:0]  data_d;
  logic               oe_d;
  logic [NUM_REQ-1:0] clr_d;

  always_comb begin
    data_d = '0;
    oe_d   = 1'b0;
    if (fire_opc) begin
      data_d = DATA_W'(OPCODE);
      oe_d   = 1'b1;
    end else if (fire_page) begin
      data_d = page_q;
      oe_d   = 1'b1;
    end else if (fire_low) begin
      data_d = low_held;
      oe_d   = 1'b1;
    end else if (poll_rd && !vec_rd) begin
      data_d = low_live;
      oe_d   = 1'b1;
    end
  end

  for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_clr
    assign clr_d[gi] = fire_opc && (win_idx == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
      clr_req <= '0;
    end else begin
      rd_data <= data_d;
      rd_oe   <= oe_d;
      clr_req <= clr_d;
    end
  end
endmodule

// File: rtl/lbr_vector_seq_chk.sv
module lbr_vector_seq_chk
  import lbr_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_REQ = 8,
  parameter logic [7:0]  OPCODE  = 8'hC0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vec_rd,
  input logic               poll_rd,
  input logic               wr_ctrl,
  input logic               defer,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_oe,
  input logic [NUM_REQ-1:0] clr_req,
  input logic               latch_clr_all,
  input logic               mask_clr_all,
  input phase_t             phase
);
  p_clr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_req));

  p_clr_with_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_req) |-> (rd_oe && rd_data == DATA_W'(OPCODE) && phase == PH_PAGE));

  p_defer_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && defer && phase == PH_OPC) |=> (phase == PH_OPC && clr_req == '0));

  p_restart_after_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && phase == PH_LOW) |=> (phase == PH_OPC));

  p_poll_no_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !vec_rd) |=> $stable(phase));

  p_pulse_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_clr_all || mask_clr_all) |-> $past(wr_ctrl));

  p_oe_from_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> $past(vec_rd || poll_rd));

  p_quiet_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));
endmodule

bind lbr_vector_seq lbr_vector_seq_chk #(
  .DATA_W(DATA_W), .NUM_REQ(NUM_REQ), .OPCODE(OPCODE)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .vec_rd(vec_rd), .poll_rd(poll_rd), .wr_ctrl(wr_ctrl), .defer(defer),
  .rd_data(rd_data), .rd_oe(rd_oe), .clr_req(clr_req),
  .latch_clr_all(latch_clr_all), .mask_clr_all(mask_clr_all),
  .phase(seq_phase)
);

// File: tb/lbr_vector_seq_test.sv
module lbr_vector_seq_test;
  logic       clk;
  logic       rst_n;
  logic       wr_page, wr_ctrl, vec_rd, poll_rd, win_vld, defer;
  logic [7:0] wr_data;
  logic [2:0] win_idx;
  logic [7:0] rd_data;
  logic       rd_oe;
  logic [7:0] clr_req;
  logic       latch_clr_all, mask_clr_all;

  int n_run  = 0;
  int n_fail = 0;

  // reference state
  logic [7:0] m_page;
  logic [7:0] m_ctrl;
  int         m_phase;
  logic [2:0] m_idx;
  // expected outputs
  logic [7:0] e_data;
  logic       e_oe;
  logic [7:0] e_clr;
  logic       e_lclr, e_mclr;

  lbr_vector_seq uut (
    .clk(clk), .rst_n(rst_n),
    .wr_page(wr_page), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .vec_rd(vec_rd), .poll_rd(poll_rd), .win_idx(win_idx),
    .win_vld(win_vld), .defer(defer),
    .rd_data(rd_data), .rd_oe(rd_oe), .clr_req(clr_req),
    .latch_clr_all(latch_clr_all), .mask_clr_all(mask_clr_all)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // low byte as the spacing requirement defines it
  function automatic logic [7:0] exp_low(input logic [7:0] ctrl, input logic [2:0] idx);
    logic [7:0] r;
    int sh;
    sh = int'(ctrl[1:0]) + 1;
    r  = {ctrl[7:4], 4'b0000};
    for (int b = 0; b < 8; b++) begin
      if (b < sh)           r[b] = 1'b0;
      else if (b < sh + 3)  r[b] = idx[b - sh];
    end
    return r;
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (rd_data !== e_data || rd_oe !== e_oe || clr_req !== e_clr ||
        latch_clr_all !== e_lclr || mask_clr_all !== e_mclr) begin
      n_fail++;
      $display("FAIL %s: data=%h oe=%b clr=%b lclr=%b mclr=%b expected data=%h oe=%b clr=%b lclr=%b mclr=%b",
               tag, rd_data, rd_oe, clr_req, latch_clr_all, mask_clr_all,
               e_data, e_oe, e_clr, e_lclr, e_mclr);
    end
  endtask

  // drive one cycle at a falling edge, predict, sample at the next falling edge
  task automatic step(input logic vr, input logic pr, input logic wp, input logic wc,
                      input logic [7:0] wd, input logic [2:0] idx, input logic vld,
                      input logic dfr, input string tag);
    vec_rd = vr; poll_rd = pr; wr_page = wp; wr_ctrl = wc; wr_data = wd;
    win_idx = idx; win_vld = vld; defer = dfr;
    e_data = 8'h00; e_oe = 1'b0; e_clr = 8'h00;
    if (vr) begin
      if (m_phase == 0) begin
        if (vld && !dfr) begin
          e_data = 8'hC0; e_oe = 1'b1; e_clr = 8'h01 << idx;
          m_idx = idx; m_phase = 1;
        end
      end else if (m_phase == 1) begin
        e_data = m_page; e_oe = 1'b1; m_phase = 2;
      end else begin
        e_data = exp_low(m_ctrl, m_idx); e_oe = 1'b1; m_phase = 0;
      end
    end else if (pr) begin
      e_data = exp_low(m_ctrl, idx); e_oe = 1'b1;
    end
    e_lclr = wc && !wd[3];
    e_mclr = wc && !wd[2];
    if (wp) m_page = wd;
    if (wc) m_ctrl = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 8'h00, 3'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    {wr_page, wr_ctrl, vec_rd, poll_rd, win_vld, defer} = '0;
    wr_data = '0; win_idx = '0;
    m_page = '0; m_ctrl = '0; m_phase = 0; m_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e_data = '0; e_oe = 0; e_clr = '0; e_lclr = 0; e_mclr = 0;
    check("R1 reset state");
    // R1: registers zero -> page byte reads 00, low byte from zero base
    step(1, 0, 0, 0, 8'h00, 3'd2, 1, 0, "R1 opcode after reset");
    step(1, 0, 0, 0, 8'h00, 3'd2, 1, 0, "R1 page zero");
    step(1, 0, 0, 0, 8'h00, 3'd2, 1, 0, "R1 low from zero ctrl");

    // R10: bits 3 and 2 high -> no pulses
    step(0, 0, 1, 0, 8'h84, 3'd0, 0, 0, "R3 page write");
    step(0, 0, 0, 1, 8'hEC, 3'd0, 0, 0, "R10 no pulse");
    // R2 / R5 / R6 / R3
    step(1, 0, 0, 0, 8'h00, 3'd4, 1, 0, "R2 R5 opcode and clear");
    step(1, 0, 0, 0, 8'h00, 3'd1, 1, 0, "R3 page byte unchanged");
    step(1, 0, 0, 0, 8'h00, 3'd1, 1, 0, "R6 frozen index low byte");
    step(1, 0, 0, 0, 8'h00, 3'd6, 1, 0, "R8 restart at opcode");
    step(1, 0, 0, 0, 8'h00, 3'd0, 1, 0, "R2 page");
    step(1, 0, 0, 0, 8'h00, 3'd0, 1, 0, "R2 low");
    // R7
    step(1, 0, 0, 0, 8'h00, 3'd3, 1, 1, "R7 deferred read");
    step(1, 0, 0, 0, 8'h00, 3'd3, 0, 0, "R7 no valid request");
    step(1, 0, 0, 0, 8'h00, 3'd3, 1, 0, "R7 opcode still next");
    step(1, 0, 0, 0, 8'h00, 3'd3, 1, 0, "R7 page");
    step(1, 0, 0, 0, 8'h00, 3'd3, 1, 0, "R7 low");
    // R4 / R9 each spacing code
    for (int c = 0; c < 4; c++) begin
      step(0, 0, 0, 1, 8'hAC | 8'(c), 3'd0, 0, 0, "R4 ctrl write");
      step(0, 1, 0, 0, 8'h00, 3'd7, 1, 0, "R4 R9 poll idx 7");
      step(0, 1, 0, 0, 8'h00, 3'd5, 0, 0, "R4 R9 poll idx 5");
    end
    // R9: poll mid-sequence does not advance or clear
    step(1, 0, 0, 0, 8'h00, 3'd2, 1, 0, "R9 opcode");
    step(0, 1, 0, 0, 8'h00, 3'd6, 1, 0, "R9 poll in sequence");
    step(1, 0, 0, 0, 8'h00, 3'd6, 1, 0, "R9 page after poll");
    // R11
    step(1, 1, 0, 0, 8'h00, 3'd6, 1, 0, "R11 vector wins");
    step(1, 1, 0, 0, 8'h00, 3'd1, 1, 1, "R11 deferred vector still blocks poll");
    // R10 pulses
    step(0, 0, 0, 1, 8'h54, 3'd0, 0, 0, "R10 latch clear pulse");
    idle("R10 pulse one cycle");
    step(0, 0, 0, 1, 8'h58, 3'd0, 0, 0, "R10 mask clear pulse");
    step(0, 0, 0, 1, 8'h50, 3'd0, 0, 0, "R10 both pulses");
    idle("R12 idle bus quiet");

    // random mix checked against the reference model
    for (int i = 0; i < 4000; i++) begin
      logic vr, pr, wp, wc;
      vr = ($urandom % 3) == 0;
      pr = ($urandom % 5) == 0;
      wp = ($urandom % 10) == 0;
      wc = !wp && (($urandom % 10) == 0);
      step(vr, pr, wp, wc, 8'($urandom), 3'($urandom), ($urandom % 5) != 0,
           ($urandom % 7) == 0, "R2 R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule